// File: doc/BRIEF.md
# Horizontal Fixed-Point Pixel Resampler

This block produces one scan line of output pixels from a line buffer of source pixels. It uses a fixed-point source position. A start-of-line strobe loads the position with a subpixel start offset. After each output pixel the position advances by a programmable step. The step is the reciprocal of the horizontal upscale factor. The offset and the step are both 12-bit unsigned values with two integer bits and ten fraction bits.

The integer part of the position selects a source pixel. The ten fraction bits weight a linear blend between that pixel and its right-hand neighbour. The blend is done on each 8-bit colour channel. A mode input turns the blend off, so the lower source pixel is repeated as it is.

The line buffer sits outside the block. It is read through two index outputs, and the addressed pixels return in the same cycle. A programmable count sets how many output pixels the block emits for each line.

Top module: `hscale_resampler`

## Requirements
- R1: After reset `pix_valid` is low. It stays low until the first `line_start` pulse has been seen.
- R2: A `line_start` pulse loads the position with `offset_q`, zero-extended, and loads the pixel count with `out_count`. The first output pixel appears with `pix_valid` high two clock edges after the edge that samples `line_start`. `pix_valid` is low in the cycle after any `line_start`.
- R3: The position advances by `step_q` after every output pixel. A step of 0x400 walks the source one pixel per output, and 0x800 takes every second source pixel.
- R4: `src_idx` is the integer part of the position, which is position bits above bit 9. The blend weight is the low 10 bits of the position.
- R5: With `replicate` low, each channel is computed as out = a + ((b - a) * frac) >>> 10. The shift is arithmetic, so it rounds toward minus infinity. Here a comes from `src_a_rgb` and b comes from `src_b_rgb`.
- R6: `src_idx_nxt` is `src_idx` + 1. The exception is when the integer part is at or beyond `last_index`: then both indices equal `last_index`, so b equals a.
- R7: With `replicate` high, each output pixel equals `src_a_rgb` at its position, and the fraction has no effect.
- R8: Exactly `out_count` pixels are emitted on consecutive cycles. After them `pix_valid` stays low until the next `line_start`. A count of 0 emits no pixel.
- R9: Pixels are packed with red in bits 23:16, green in 15:8 and blue in 7:0. Each channel is blended independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Start-of-line strobe |
| step_q | input | 12 | Source step per output pixel, 2.10 |
| offset_q | input | 12 | Start position, 2.10 |
| replicate | input | 1 | 1 = repeat lower pixel, 0 = blend |
| out_count | input | 11 | Output pixels per line |
| last_index | input | 10 | Index of the last source pixel |
| src_idx | output | 10 | Read index of the lower source pixel |
| src_idx_nxt | output | 10 | Read index of the upper source pixel |
| src_a_rgb | input | 24 | Pixel at `src_idx`, same cycle |
| src_b_rgb | input | 24 | Pixel at `src_idx_nxt`, same cycle |
| pix_valid | output | 1 | Output pixel valid |
| pix_rgb | output | 24 | Output pixel |

## Verification
The assertions assume that the line buffer answers both read indices combinationally within the same cycle. They also assume that `replicate`, `step_q` and `last_index` stay steady while a line is being produced. The bench models the buffer as a pure function of the index and changes the settings only between lines. It keeps every position within the accumulator range, so the checks on blend bounds and replication see consistent source data.

// File: rtl/hscale_resampler.sv
module hscale_resampler #(
  parameter int IDX_W  = 10,
  parameter int CNT_W  = 11,
  parameter int PIX_W  = 8,
  parameter int FLD_W  = 12,
  parameter int FRAC_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic [FLD_W-1:0]   step_q,
  input  logic [FLD_W-1:0]   offset_q,
  input  logic               replicate,
  input  logic [CNT_W-1:0]   out_count,
  input  logic [IDX_W-1:0]   last_index,
  output logic [IDX_W-1:0]   src_idx,
  output logic [IDX_W-1:0]   src_idx_nxt,
  input  logic [3*PIX_W-1:0] src_a_rgb,
  input  logic [3*PIX_W-1:0] src_b_rgb,
  output logic               pix_valid,
  output logic [3*PIX_W-1:0] pix_rgb
);
  localparam int ACC_W = IDX_W + FRAC_W;

  logic [ACC_W-1:0]   acc;
  logic [CNT_W-1:0]   remain;
  logic [IDX_W-1:0]   whole;
  logic [FRAC_W-1:0]  frac;
  logic               at_end;
  logic [3*PIX_W-1:0] mix;

  assign whole       = acc[ACC_W-1:FRAC_W];
  assign frac        = acc[FRAC_W-1:0];
  assign at_end      = whole >= last_index;
  assign src_idx     = at_end ? last_index : whole;
  assign src_idx_nxt = at_end ? last_index : whole + 1'b1;

  for (genvar c = 0; c < 3; c++) begin : g_chan
    logic [PIX_W-1:0]              a, b;
    logic signed [PIX_W+1:0]       diff;
    logic signed [PIX_W+FRAC_W+2:0] prod;
    assign a    = src_a_rgb[c*PIX_W +: PIX_W];
    assign b    = src_b_rgb[c*PIX_W +: PIX_W];
    assign diff = $signed({2'b00, b}) - $signed({2'b00, a});
    assign prod = diff * $signed({1'b0, frac});
    assign mix[c*PIX_W +: PIX_W] = replicate ? a : a + prod[FRAC_W +: PIX_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      remain    <= '0;
      pix_valid <= 1'b0;
      pix_rgb   <= '0;
    end else if (line_start) begin
      acc       <= ACC_W'(offset_q);
      remain    <= out_count;
      pix_valid <= 1'b0;
    end else if (remain != '0) begin
      pix_valid <= 1'b1;
      pix_rgb   <= mix;
      acc       <= acc + ACC_W'(step_q);
      remain    <= remain - 1'b1;
    end else begin
      pix_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/hscale_resampler_chk.sv
module hscale_resampler_chk #(
  parameter int IDX_W = 10,
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_start,
  input logic               replicate,
  input logic [IDX_W-1:0]   src_idx,
  input logic [IDX_W-1:0]   src_idx_nxt,
  input logic [3*PIX_W-1:0] src_a_rgb,
  input logic [3*PIX_W-1:0] src_b_rgb,
  input logic               pix_valid,
  input logic [3*PIX_W-1:0] pix_rgb
);
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !pix_valid); // R2
  AST_VALID_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> $past(line_start, 2)); // R8
  AST_NEIGHBOUR_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx_nxt == src_idx) || (src_idx_nxt == src_idx + 1'b1)); // R6
  AST_REPLICATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(replicate)) |-> pix_rgb == $past(src_a_rgb)); // R7
  AST_RED_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |->
      ((pix_rgb[3*PIX_W-1:2*PIX_W] >= $past(src_a_rgb[3*PIX_W-1:2*PIX_W]) &&
        pix_rgb[3*PIX_W-1:2*PIX_W] <= $past(src_b_rgb[3*PIX_W-1:2*PIX_W])) ||
       (pix_rgb[3*PIX_W-1:2*PIX_W] <= $past(src_a_rgb[3*PIX_W-1:2*PIX_W]) &&
        pix_rgb[3*PIX_W-1:2*PIX_W] >= $past(src_b_rgb[3*PIX_W-1:2*PIX_W])))); // R5
  AST_BLUE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |->
      ((pix_rgb[PIX_W-1:0] >= $past(src_a_rgb[PIX_W-1:0]) &&
        pix_rgb[PIX_W-1:0] <= $past(src_b_rgb[PIX_W-1:0])) ||
       (pix_rgb[PIX_W-1:0] <= $past(src_a_rgb[PIX_W-1:0]) &&
        pix_rgb[PIX_W-1:0] >= $past(src_b_rgb[PIX_W-1:0])))); // R9
endmodule

bind hscale_resampler hscale_resampler_chk #(.IDX_W(IDX_W), .PIX_W(PIX_W)) u_chk (.*);

// File: tb/hscale_resampler_bench.sv
module hscale_resampler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic [11:0] step_q = '0, offset_q = '0;
  logic        replicate = 1'b0;
  logic [10:0] out_count = '0;
  logic [9:0]  last_index = '0;
  logic [9:0]  src_idx, src_idx_nxt;
  logic [23:0] src_a_rgb, src_b_rgb;
  logic        pix_valid;
  logic [23:0] pix_rgb;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  function automatic logic [23:0] srcpix(input int i);
    logic [7:0] r, g, b;
    r = 8'((i * 37 + 5) & 255);
    g = 8'((i * 91 + 200) & 255);
    b = 8'((255 - i * 13) & 255);
    return {r, g, b};
  endfunction

  assign src_a_rgb = srcpix(int'(src_idx));
  assign src_b_rgb = srcpix(int'(src_idx_nxt));

  hscale_resampler u_hscale_resampler (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && pix_valid && !done) begin
    if (exp_q.size() == 0) check(0, cur_req, "unexpected pixel", int'(pix_rgb), 0);
    else begin
      logic [23:0] e;
      e = exp_q.pop_front();
      check(pix_rgb == e, cur_req, "pixel", int'(pix_rgb), int'(e));
    end
  end

  task automatic run_line(input int off, input int stp, input int cnt,
                          input bit rep, input int last, input string req);
    int acc;
    @(negedge clk);
    cur_req = req;
    offset_q = 12'(off); step_q = 12'(stp); out_count = 11'(cnt);
    replicate = rep; last_index = 10'(last);
    acc = off;
    for (int k = 0; k < cnt; k++) begin
      int i, f, ia, ib;
      logic [23:0] pa, pb, pe;
      i = acc >> 10; f = acc & 1023;
      ia = (i >= last) ? last : i;
      ib = (i >= last) ? last : i + 1;
      pa = srcpix(ia); pb = srcpix(ib);
      for (int c = 0; c < 3; c++) begin
        int a, b, d;
        a = int'(pa[c*8 +: 8]); b = int'(pb[c*8 +: 8]);
        d = ((b - a) * f) >>> 10;
        pe[c*8 +: 8] = rep ? 8'(a) : 8'(a + d);
      end
      exp_q.push_back(pe);
      acc += stp;
    end
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    check(!pix_valid, req, "valid low after strobe", int'(pix_valid), 0);
    repeat (cnt + 3) @(negedge clk);
    check(exp_q.size() == 0, req, "pixels missing", exp_q.size(), 0);
    check(!pix_valid, req, "valid low after count", int'(pix_valid), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pix_valid, "R1", "valid in reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!pix_valid, "R1", "valid before first line", int'(pix_valid), 0);
    run_line(0,     12'h400, 16, 0, 31, "R3 unit step");
    run_line(12'h200, 12'h800, 10, 0, 31, "R3 double step");
    run_line(0,     12'h200, 20, 0, 31, "R5 half step blend");
    run_line(12'h0A3, 12'h155, 60, 0, 15, "R6 clamp at last");
    run_line(12'h0A3, 12'h155, 30, 1, 31, "R7 replicate");
    run_line(12'hFFF, 12'h3FF, 12, 0, 40, "R4 fraction");
    run_line(12'h123, 12'h2C7, 25, 0, 63, "R9 channels");
    run_line(12'h200, 12'h400, 0, 0, 31, "R8 zero count");
    run_line(12'h080, 12'h4A1, 40, 0, 50, "R2 offset load");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule